// File: doc/BRIEF.md
# Serial DAC Channel Register Loader

This block takes 12-bit command words over a three-wire serial link (serial clock, serial data and a load strobe) and stores them in a bank of ten 8-bit channel registers. Each command carries a 4-bit channel select in its upper bits and a data byte in its lower bits. Eight of the channels are reference codes for voltage DAC channels, where code N stands for N/256 of the reference. The other two channels hold the write and erase gain settings. For these two, the data byte is split into an enable flag for an internal resistor ladder and a 7-bit code.

The serial pins run asynchronously to the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain. The system clock therefore has to run at least eight times faster than the serial clock. A word is committed on the rising edge of the load strobe, but only when exactly twelve bits arrived while the strobe was low. When a register is written, the block raises a one-cycle pulse and presents the channel index with it.

Top module: `dac_serial_loader`

## Requirements
- R1: Frames are sent MSB first. The first bit after the load strobe falls lands in D11. Bits D11..D8 form the channel select and bits D7..D0 form the data byte.
- R2: A bit is captured only on a rising serial clock edge while the load strobe is low. Serial clock edges while the strobe is high are ignored.
- R3: While the active-low reset is low, every channel register, both enable flags, both ladder codes and the update pulse read 0.
- R4: Select codes 1 to 8 address reference channels 0 to 7, code 9 addresses the write channel and code 10 addresses the erase channel. Codes 0 and 11 to 15 change no register and raise no update pulse.
- R5: A write to reference channel k (select k+1) stores the full data byte. The byte appears on `ref_codes[8k+7:8k]`.
- R6: A write to the write or erase channel stores D0 as the ladder enable flag (1 enables the ladder) and D7..D1 as the 7-bit ladder code, with D1 as the LSB.
- R7: A word is committed on the rising edge of the load strobe only when exactly 12 bits were captured since the strobe fell. A frame of 11 or 13 bits, or a strobe pulse with no bits, changes nothing.
- R8: A commit changes only the addressed register. All other registers keep their values.
- R9: Every commit to a valid channel raises `upd_pulse` for exactly one system clock cycle. During that cycle `upd_chan` equals the select code.
- R10: The registers and the update pulse change at the fourth rising system clock edge after the load strobe rises at the pin, and they do not change at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Load strobe, low while a frame is shifted in, idles high |
| ref_codes | output | 64 | Eight reference channel codes, channel k at bits 8k+7..8k |
| wr_ladder_en | output | 1 | Write channel ladder enable flag |
| wr_code | output | 7 | Write channel ladder code |
| er_ladder_en | output | 1 | Erase channel ladder enable flag |
| er_code | output | 7 | Erase channel ladder code |
| upd_pulse | output | 1 | One-cycle pulse on each register commit |
| upd_chan | output | 4 | Select code of the last commit |

## Verification
The bound checker watches four things on every cycle. Any change in a register group must coincide with an update pulse that names a channel in that group. The update pulse never lasts two cycles. Its channel index is always a legal code. Every output reads zero under reset.

Some behaviours need the bench's scenarios. These are the select-code mapping and the bit order within a frame, and the discarding of short, long and empty frames. The bench also covers clock edges with the strobe high and the exact commit latency. It sweeps all sixteen select codes under several data patterns against an arithmetic model.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int unsigned DFLT_DATA_W  = 8;
  localparam int unsigned DFLT_SEL_W   = 4;
  localparam int unsigned DFLT_NUM_REF = 8;
  localparam int unsigned DFLT_SYNC    = 2;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= {W{RST_VAL}};
      else        stg[g] <= stg_d;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dacld_shifter.sv
module dacld_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdat_s,
  input  logic               sld_s,
  output logic [FRAME_W-1:0] word,
  output logic               word_vld
);
  localparam int unsigned CNT_MAX = FRAME_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_q, sld_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_base;
  logic               vld_q, vld_d;
  logic               sclk_rise, ld_fall, ld_rise, shift_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    ld_fall   = ~sld_s & sld_q;
    ld_rise   = sld_s & ~sld_q;
    shift_en  = sclk_rise & ~sld_s;

    shreg_d  = shreg_q;
    cnt_base = ld_fall ? '0 : cnt_q;
    cnt_d    = cnt_base;
    if (shift_en) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdat_s};
      if (cnt_base != CNT_W'(CNT_MAX)) cnt_d = cnt_base + CNT_W'(1);
    end
    vld_d = ld_rise && (cnt_q == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      sld_q   <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      sld_q   <= sld_s;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
    end
  end

  assign word     = shreg_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/dacld_decode.sv
module dacld_decode #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_REF = 8
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_REF-1:0] ref_hit,
  output logic [1:0]         lad_hit
);
  for (genvar k = 0; k < NUM_REF; k++) begin : g_ref
    assign ref_hit[k] = (sel == SEL_W'(k + 1));
  end
  for (genvar j = 0; j < 2; j++) begin : g_lad
    assign lad_hit[j] = (sel == SEL_W'(NUM_REF + 1 + j));
  end
endmodule

// File: rtl/dacld_bank.sv
module dacld_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_REF = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [NUM_REF-1:0]        ref_hit,
  input  logic [1:0]                lad_hit,
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         data,
  output logic [NUM_REF*DATA_W-1:0] ref_codes,
  output logic [1:0]                lad_en,
  output logic [2*(DATA_W-1)-1:0]   lad_code,
  output logic                      upd_pulse,
  output logic [SEL_W-1:0]          upd_chan
);
  localparam int unsigned CODE_W = DATA_W - 1;

  for (genvar k = 0; k < NUM_REF; k++) begin : g_ref
    logic [DATA_W-1:0] ref_q;
    logic              wr_en;
    assign wr_en = commit & ref_hit[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ref_q <= '0;
      else if (wr_en) ref_q <= data;
    end
    assign ref_codes[k*DATA_W +: DATA_W] = ref_q;
  end

  for (genvar j = 0; j < 2; j++) begin : g_lad
    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              wr_en;
    assign wr_en = commit & lad_hit[j];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        code_q <= '0;
      end else if (wr_en) begin
        en_q   <= data[0];
        code_q <= data[DATA_W-1:1];
      end
    end
    assign lad_en[j]                    = en_q;
    assign lad_code[j*CODE_W +: CODE_W] = code_q;
  end

  logic             pulse_d, pulse_q;
  logic [SEL_W-1:0] chan_d, chan_q;

  always_comb begin
    pulse_d = commit & ((|ref_hit) | (|lad_hit));
    chan_d  = pulse_d ? sel : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      pulse_q <= pulse_d;
      chan_q  <= chan_d;
    end
  end

  assign upd_pulse = pulse_q;
  assign upd_chan  = chan_q;
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dacld_pkg::*;
#(
  parameter int unsigned DATA_W      = DFLT_DATA_W,
  parameter int unsigned SEL_W       = DFLT_SEL_W,
  parameter int unsigned NUM_REF     = DFLT_NUM_REF,
  parameter int unsigned SYNC_STAGES = DFLT_SYNC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      ser_ld,
  output logic [NUM_REF*DATA_W-1:0] ref_codes,
  output logic                      wr_ladder_en,
  output logic [DATA_W-2:0]         wr_code,
  output logic                      er_ladder_en,
  output logic [DATA_W-2:0]         er_code,
  output logic                      upd_pulse,
  output logic [SEL_W-1:0]          upd_chan
);
  localparam int unsigned FRAME_W = SEL_W + DATA_W;
  localparam int unsigned CODE_W  = DATA_W - 1;

  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic [1:0] ctl_s;
  logic [0:0] dat_s;

  dacld_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ctl (
    .clk(clk), .rst_n(rst_i_n), .din({ser_clk, ser_ld}), .dout(ctl_s)
  );
  dacld_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_i_n), .din(ser_dat), .dout(dat_s)
  );

  logic [FRAME_W-1:0] word;
  logic               word_vld;

  dacld_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n),
    .sclk_s(ctl_s[1]), .sdat_s(dat_s[0]), .sld_s(ctl_s[0]),
    .word(word), .word_vld(word_vld)
  );

  logic [SEL_W-1:0]   sel;
  logic [DATA_W-1:0]  data;
  logic [NUM_REF-1:0] ref_hit;
  logic [1:0]         lad_hit;
  assign sel  = word[FRAME_W-1 -: SEL_W];
  assign data = word[DATA_W-1:0];

  dacld_decode #(.SEL_W(SEL_W), .NUM_REF(NUM_REF)) u_dec (
    .sel(sel), .ref_hit(ref_hit), .lad_hit(lad_hit)
  );

  logic [1:0]          lad_en;
  logic [2*CODE_W-1:0] lad_code;

  dacld_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REF(NUM_REF)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .commit(word_vld),
    .ref_hit(ref_hit), .lad_hit(lad_hit), .sel(sel), .data(data),
    .ref_codes(ref_codes), .lad_en(lad_en), .lad_code(lad_code),
    .upd_pulse(upd_pulse), .upd_chan(upd_chan)
  );

  assign wr_ladder_en = lad_en[0];
  assign er_ladder_en = lad_en[1];
  assign wr_code      = lad_code[0 +: CODE_W];
  assign er_code      = lad_code[CODE_W +: CODE_W];
endmodule

// File: rtl/dacld_checker.sv
module dacld_checker #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_REF = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REF*DATA_W-1:0] ref_codes,
  input logic                      wr_ladder_en,
  input logic [DATA_W-2:0]         wr_code,
  input logic                      er_ladder_en,
  input logic [DATA_W-2:0]         er_code,
  input logic                      upd_pulse,
  input logic [SEL_W-1:0]          upd_chan
);
  localparam logic [SEL_W-1:0] CH_WR = SEL_W'(NUM_REF + 1);
  localparam logic [SEL_W-1:0] CH_ER = SEL_W'(NUM_REF + 2);

  p_upd_chan_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> (upd_chan != '0) && (upd_chan <= CH_ER));

  p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  p_ref_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_codes) |-> upd_pulse && (upd_chan != '0) && (upd_chan < CH_WR));

  p_wr_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wr_ladder_en, wr_code}) |-> upd_pulse && (upd_chan == CH_WR));

  p_er_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({er_ladder_en, er_code}) |-> upd_pulse && (upd_chan == CH_ER));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r3: assert (ref_codes == '0 && !wr_ladder_en && wr_code == '0 &&
                                !er_ladder_en && er_code == '0 && !upd_pulse);
    end
  end
endmodule

bind dac_serial_loader dacld_checker #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REF(NUM_REF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_codes(ref_codes),
  .wr_ladder_en(wr_ladder_en), .wr_code(wr_code),
  .er_ladder_en(er_ladder_en), .er_code(er_code),
  .upd_pulse(upd_pulse), .upd_chan(upd_chan)
);

// File: tb/dac_serial_loader_tb.sv
module dac_serial_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_dat, ser_ld;
  logic [63:0] ref_codes;
  logic        wr_ladder_en, er_ladder_en;
  logic [6:0]  wr_code, er_code;
  logic        upd_pulse;
  logic [3:0]  upd_chan;

  always #2.5 clk = ~clk;

  dac_serial_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .ref_codes(ref_codes), .wr_ladder_en(wr_ladder_en), .wr_code(wr_code),
    .er_ladder_en(er_ladder_en), .er_code(er_code),
    .upd_pulse(upd_pulse), .upd_chan(upd_chan)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int pulses = 0;
  logic [3:0] last_chan = '0;

  logic [7:0] m_ref [8];
  logic       m_wr_en, m_er_en;
  logic [6:0] m_wr_code, m_er_code;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && upd_pulse === 1'b1) begin
      pulses++;
      last_chan = upd_chan;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = m_ref[k];
    return f;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 8; k++) m_ref[k] = '0;
    m_wr_en = 0; m_er_en = 0; m_wr_code = '0; m_er_code = '0;
  endtask

  task automatic model_apply(input logic [3:0] sel, input logic [7:0] d);
    if (sel >= 1 && sel <= 8) m_ref[sel-1] = d;
    else if (sel == 9)  begin m_wr_en = d[0]; m_wr_code = d[7:1]; end
    else if (sel == 10) begin m_er_en = d[0]; m_er_code = d[7:1]; end
  endtask

  task automatic check_state(input string req);
    check(ref_codes === model_flat(), {req, " ref"}, ref_codes, model_flat());
    check({wr_ladder_en, wr_code} === {m_wr_en, m_wr_code}, {req, " write"},
          {wr_ladder_en, wr_code}, {m_wr_en, m_wr_code});
    check({er_ladder_en, er_code} === {m_er_en, m_er_code}, {req, " erase"},
          {er_ladder_en, er_code}, {m_er_en, m_er_code});
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // shifts n bits MSB first; leaves the strobe low when keep_low is set
  task automatic shift_bits(input logic [15:0] bits, input int n, input bit keep_low);
    ser_ld = 1'b0;
    half();
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      ser_clk = 1'b0; half();
      ser_clk = 1'b1; half();
    end
    if (!keep_low) begin
      ser_ld = 1'b1;
      half(); half();
    end
  endtask

  task automatic send_word(input logic [3:0] sel, input logic [7:0] d, input string req);
    int p0;
    p0 = pulses;
    shift_bits({4'b0, sel, d}, 12, 1'b0);
    model_apply(sel, d);
    check_state(req);
    if (sel >= 1 && sel <= 10) begin
      check(pulses == p0 + 1, "R9 pulse count", pulses - p0, 1);
      check(last_chan == sel, "R9 channel index", last_chan, sel);
    end else begin
      check(pulses == p0, "R4 no pulse on unused select", pulses - p0, 0);
    end
  endtask

  initial begin
    int p0;
    ser_clk = 1'b1; ser_dat = 1'b0; ser_ld = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    model_clear();
    repeat (4) @(negedge clk);
    check_state("R3 reset");
    check(upd_pulse === 1'b0, "R3 pulse in reset", upd_pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R3 after release");

    // R1 R4 R5 R6 R8: sweep every select code under several data patterns
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        case (p)
          0: d = 8'hFF;
          1: d = 8'hA5 ^ {4'(s), 4'(s)};
          2: d = 8'h3C + 8'(s * 7);
          default: d = 8'h00 + 8'(s);
        endcase
        send_word(4'(s), d, "R1 R4 R5 R6 R8 sweep");
      end
    end

    // R6: enable flag set and clear with extreme codes
    send_word(4'd9,  8'b1111_1110, "R6 write code max enable off");
    send_word(4'd10, 8'b0000_0011, "R6 erase code 1 enable on");

    // R7: short, long and empty frames are discarded
    p0 = pulses;
    shift_bits({4'b0, 4'd1, 8'h77}, 11, 1'b0);
    check_state("R7 eleven bits");
    shift_bits({3'b0, 1'b1, 4'd2, 8'h66}, 13, 1'b0);
    check_state("R7 thirteen bits");
    shift_bits(16'h0, 0, 1'b0);
    check_state("R7 empty strobe");
    check(pulses == p0, "R7 no pulse", pulses - p0, 0);

    // R2: serial clock toggles with the strobe high are ignored
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0]; ser_clk = 1'b0; half(); ser_clk = 1'b1; half();
    end
    check_state("R2 clocks with strobe high");
    send_word(4'd2, 8'h12, "R2 word after idle clocks");

    // R10: commit latency counted from the strobe rising at the pin
    shift_bits({4'b0, 4'd3, 8'hC9}, 12, 1'b1);
    ser_ld = 1'b1;
    repeat (3) @(negedge clk);
    check(ref_codes[23:16] === m_ref[2], "R10 not yet at third edge", ref_codes[23:16], m_ref[2]);
    check(upd_pulse === 1'b0, "R10 no pulse at third edge", upd_pulse, 0);
    @(negedge clk);
    check(ref_codes[23:16] === 8'hC9, "R10 update at fourth edge", ref_codes[23:16], 8'hC9);
    check(upd_pulse === 1'b1, "R10 pulse at fourth edge", upd_pulse, 1);
    model_apply(4'd3, 8'hC9);
    half();

    // R3: reset in mid operation clears everything
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check_state("R3 mid-run reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_word(4'd8, 8'h81, "R5 after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule